// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four incoming modem handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It also drives two outgoing control pins, data-terminal-ready and request-to-send. Each incoming line passes through a synchroniser. The block then compares the line with the value it held one cycle earlier. A change sets a sticky flag in the low half of an 8-bit status byte, and the high half of that byte carries the current synchronised line levels.

Software reads the status byte and pulses a read strobe. The strobe clears the change flags. A level-sensitive interrupt request is raised while any change flag is set and the modem interrupt enable is high. The ring flag records only the end of a ring: the ring line going from active to inactive. The other three flags record either edge of their line. A small control register, written through a write strobe with data, drives the two outgoing pins.

Top module: `modem_watch`

## Requirements
- R1: `line_in` is mapped as bit 0 clear-to-send, bit 1 data-set-ready, bit 2 ring indicator, bit 3 carrier detect. Status bits 7..4 show carrier detect, ring indicator, data-set-ready and clear-to-send after `SYNC_STAGES` clock edges of synchronisation.
- R2: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) are change flags. Each is set on either edge of its synchronised line, one clock edge after the new level appears in bits 7..4. Each stays set until it is cleared.
- R3: A cycle with `status_rd` high clears status bits 3..0 at the next clock edge.
- R4: Status bit 2 is set only when the synchronised ring indicator goes from 1 to 0. A 0-to-1 transition leaves it unchanged.
- R5: `irq` is high exactly when `irq_en` is high and any of status bits 3..0 is set. Dropping `irq_en` drops `irq` in the same cycle, with no clock edge needed.
- R6: A cycle with `ctl_we` high stores `ctl_wdata[1:0]`. Stored bit 0 drives `dtr` and stored bit 1 drives `rts`. Both reset to 0. `ctl_rdata` returns the stored pair in bits 1..0, with bits 7..2 reading 0.
- R7: If a change is detected in the same cycle as `status_rd`, the change flag for that line is set after the edge rather than cleared.
- R8: Reset clears all change flags. Line levels present during and right after reset do not set any flag, because the first synchronised sample becomes the comparison value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 4 | Raw modem lines, active high: {carrier, ring, data-set-ready, clear-to-send} |
| status_rd | input | 1 | Status byte read strobe; clears the change flags |
| irq_en | input | 1 | Modem status interrupt enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bits 1..0 are used |
| status | output | 8 | {line levels[3:0], change flags[3:0]} |
| ctl_rdata | output | 8 | Control register readback |
| dtr | output | 1 | Data-terminal-ready pin |
| rts | output | 1 | Request-to-send pin |
| irq | output | 1 | Modem status interrupt request |

## Verification
The bench builds the block with the default two-stage synchroniser. The level-to-flag delay is therefore three edges, which lets a directed test place a read strobe in exactly the cycle where a change is detected. The bench holds lines high through reset to show that the priming window produces no flag. It also drives the ring line through both directions, so that only the falling transition is seen to register. A behavioural model tracks the synchroniser depth, the priming count and the sticky flags, and it is compared with the outputs on every cycle.

// File: rtl/modem_watch.sv
module modem_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] line_in,
  input  logic       status_rd,
  input  logic       irq_en,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] status,
  output logic [7:0] ctl_rdata,
  output logic       dtr,
  output logic       rts,
  output logic       irq
);
  localparam int FILL_W = $clog2(SYNC_STAGES + 2);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(SYNC_STAGES + 1);
  localparam logic [3:0] BOTH_EDGES = 4'b1011;
  localparam logic [3:0] FALL_ONLY  = 4'b0100;

  logic [3:0]        sync_q [SYNC_STAGES];
  logic [3:0]        prev_q, delta_q, sync_out, edge_hit;
  logic [FILL_W-1:0] fill_q;
  logic [1:0]        ctl_q;
  logic              armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= line_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign sync_out = sync_q[SYNC_STAGES-1];
  assign armed    = (fill_q == FILL_MAX);
  assign edge_hit = armed ? (((sync_out ^ prev_q) & BOTH_EDGES) |
                             (prev_q & ~sync_out & FALL_ONLY)) : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      fill_q  <= '0;
      delta_q <= '0;
      ctl_q   <= '0;
    end else begin
      prev_q  <= sync_out;
      if (!armed) fill_q <= fill_q + 1'b1;
      delta_q <= (status_rd ? 4'b0000 : delta_q) | edge_hit;
      if (ctl_we) ctl_q <= ctl_wdata[1:0];
    end
  end

  assign status    = {sync_out, delta_q};
  assign ctl_rdata = {6'b000000, ctl_q};
  assign dtr       = ctl_q[0];
  assign rts       = ctl_q[1];
  assign irq       = irq_en & (|delta_q);
endmodule

// File: rtl/modem_watch_chk.sv
module modem_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       status_rd,
  input logic       irq_en,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] status,
  input logic       dtr,
  input logic       rts,
  input logic       irq,
  input logic [3:0] sync_q,
  input logic [3:0] prev_q,
  input logic       armed
);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !status_rd) |=> status[0]);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && sync_q == prev_q) |=> status[3:0] == 4'b0000);
  p_ring_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[2] && !(prev_q[2] && !sync_q[2])) |=> !status[2]);
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[3:0] != 4'b0000);
  p_ctl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> {rts, dtr} == $past(ctl_wdata[1:0]));
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && armed && sync_q[0] != prev_q[0]) |=> status[0]);
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> status[3:0] == 4'b0000);
endmodule

bind modem_watch modem_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status_rd(status_rd), .irq_en(irq_en),
  .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .status(status), .dtr(dtr),
  .rts(rts), .irq(irq), .sync_q(sync_out), .prev_q(prev_q), .armed(armed)
);

// File: tb/modem_watch_tb.sv
module modem_watch_tb;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] line_in = 4'b1010;
  logic       status_rd = 1'b0, irq_en = 1'b0, ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] status, ctl_rdata;
  logic       dtr, rts, irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  modem_watch #(.SYNC_STAGES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .status_rd(status_rd),
    .irq_en(irq_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .status(status), .ctl_rdata(ctl_rdata), .dtr(dtr), .rts(rts), .irq(irq)
  );

  // behavioural reference
  logic [3:0] m_pipe [S];
  logic [3:0] m_prev, m_delta, m_old, m_hit;
  logic [1:0] m_ctl;
  int         m_fill;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < S; i++) m_pipe[i] = 4'b0;
      m_prev = 4'b0; m_delta = 4'b0; m_ctl = 2'b0; m_fill = 0;
    end else begin
      m_old = m_pipe[S-1];
      m_hit = 4'b0;
      if (m_fill == S + 1) begin
        for (int b = 0; b < 4; b++) begin
          if (b == 2) m_hit[b] = m_prev[b] && !m_old[b];
          else        m_hit[b] = m_prev[b] != m_old[b];
        end
      end
      if (status_rd) m_delta = 4'b0;
      m_delta = m_delta | m_hit;
      m_prev = m_old;
      for (int i = S - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = line_in;
      if (m_fill < S + 1) m_fill++;
      if (ctl_we) m_ctl = ctl_wdata[1:0];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 levels", {4'b0, status[7:4]}, {4'b0, m_pipe[S-1]});
      chk("R2 flags", {4'b0, status[3:0]}, {4'b0, m_delta});
      chk("R5 irq", {7'b0, irq}, {7'b0, irq_en & (m_delta != 4'b0)});
      chk("R6 ctl", ctl_rdata, {6'b0, m_ctl});
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(6);
    chk("R8 no flag from reset levels", status, 8'hA0);
    chk("R6 reset value", {5'b0, rts, dtr, 1'b0}, 8'h00);
    line_in = 4'b1011;
    tick(2);
    chk("R1 level after sync", status, 8'hB0);
    tick(1);
    chk("R2 cts rise flag", status, 8'hB1);
    chk("R5 disabled irq", {7'b0, irq}, 8'h00);
    irq_en = 1'b1;
    tick(1);
    chk("R5 enabled irq", {7'b0, irq}, 8'h01);
    irq_en = 1'b0;
    #1 chk("R5 immediate drop", {7'b0, irq}, 8'h00);
    irq_en = 1'b1;
    status_rd = 1'b1; tick(1); status_rd = 1'b0;
    chk("R3 read clears", status, 8'hB0);
    chk("R3 irq after clear", {7'b0, irq}, 8'h00);
    line_in = 4'b1111;
    tick(4);
    chk("R4 ring rise ignored", status, 8'hF0);
    line_in = 4'b1011;
    tick(4);
    chk("R4 ring fall flag", status, 8'hB4);
    status_rd = 1'b1; tick(1); status_rd = 1'b0;
    chk("R3 clear ring flag", status, 8'hB0);
    line_in = 4'b1010;
    tick(2);
    status_rd = 1'b1; tick(1); status_rd = 1'b0;
    chk("R7 change during read kept", status, 8'hA1);
    status_rd = 1'b1; tick(1); status_rd = 1'b0;
    line_in = 4'b0000;
    tick(4);
    chk("R2 dcd and dsr fall flags", status, 8'h0A);
    ctl_we = 1'b1; ctl_wdata = 8'hFF; tick(1); ctl_we = 1'b0;
    chk("R6 readback masks upper", ctl_rdata, 8'h03);
    chk("R6 pins high", {6'b0, rts, dtr}, 8'h03);
    ctl_we = 1'b1; ctl_wdata = 8'h02; tick(1); ctl_we = 1'b0;
    chk("R6 dtr low rts high", {6'b0, rts, dtr}, 8'h02);
    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule